// File: doc/BRIEF.md
# Majority-Gate Full Adder with Defect Emulation

This block is a one-bit full adder assembled only from three three-input majority gates and two inverting wires, with a fault-select input that swaps in one logic-level defect model at a time. The defect models are those seen in cell-based majority logic. An inverting wire can gain an extra inversion. A coplanar crossing can let a faulty inverting wire take over the plain wire it crosses. A majority gate can collapse onto its horizontal input. A defective gate centre can complement both vertical inputs. A damaged horizontal input cell leaves the gate intact.

The netlist has five nodes. The carry gate G1 computes MAJ(a, b, cin), with a and cin as vertical inputs and b as horizontal. An inverting wire W1 carries ~cin. The helper gate G2 computes MAJ(a, b, W1), with b horizontal. A second inverting wire W2 carries ~G1. The sum gate G3 computes MAJ(W2, G2, cin), with G2 horizontal. The crossings are W1 over the b feed into G2, and W2 over the G2 feed into G3. A fault introduced upstream propagates through the real netlist, so a fault in G1 also changes the sum. When `REG_OUT` is 1, which is the default, both outputs pass through one register stage that has a synchronous reset.

Top module: `majfa_defect`

## Requirements
- R1: With fault code 0, {cout, sum} equals the two-bit arithmetic sum a+b+cin, and it appears one clock after the inputs are sampled.
- R2: While rst is high at a clock edge, both registered outputs become 0 at that edge, whatever the other inputs are.
- R3: Code 1 adds an inversion to W1, which makes sum equal cin while cout stays correct. Code 2 adds an inversion to W2, which makes sum = MAJ(cout, G2, cin) while cout stays correct.
- R4: Code 3 is a defect at the W1 crossing: W1 carries cin and the b feed into G2 carries the same value, so sum = cin. Code 4 is a defect at the W2 crossing: W2 carries cout and the G2 feed into G3 carries the same value, so sum = cout. In both cases cout stays correct.
- R5: Code 5 makes cout = b. Code 6 makes G2 = b. Code 7 makes sum = G2. Each of these is a vertical-input defect in G1, G2 and G3 respectively, and any change to cout carries through to sum.
- R6: Code 8 makes cout = MAJ(~a, b, ~cin). Code 9 makes G2 = MAJ(~a, b, cin). Code 10 makes sum = MAJ(cout, G2, ~cin). These are centre-cell defects, and a faulty cout carries through to sum.
- R7: Codes 11, 12 and 13 are horizontal-cell defects in G1, G2 and G3. Each of them gives the fault-free outputs.
- R8: Codes 14 and 15 are unassigned and give the fault-free outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 1 | First addend bit |
| b | input | 1 | Second addend bit |
| cin | input | 1 | Carry in |
| fault_sel | input | 4 | Defect code, 0 = fault-free |
| sum | output | 1 | Sum bit |
| cout | output | 1 | Carry out |

## Verification
The hardest cases to observe are the faults in the carry gate, codes 5 and 8. They reach sum only through the inverting wire and the sum gate, so a check on sum alone cannot separate a propagated fault from a local one. The stimulus therefore steps through all sixteen codes against all eight input patterns and compares both outputs every cycle. One pass applies a reset in the middle of the run while inputs that give non-zero outputs are held, so the reset has a visible effect to check.

// File: rtl/majfa_defect.sv
module majfa_defect #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       a,
  input  logic       b,
  input  logic       cin,
  input  logic [3:0] fault_sel,
  output logic       sum,
  output logic       cout
);

  function automatic logic maj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  logic w1_flip, w2_flip, x1, x2;
  logic v1, v2, v3, c1, c2, c3;
  logic w1, w2, g1, g2, g2_h, g3_h, g3;

  assign w1_flip = (fault_sel == 4'd1);
  assign w2_flip = (fault_sel == 4'd2);
  assign x1      = (fault_sel == 4'd3);
  assign x2      = (fault_sel == 4'd4);
  assign v1      = (fault_sel == 4'd5);
  assign v2      = (fault_sel == 4'd6);
  assign v3      = (fault_sel == 4'd7);
  assign c1      = (fault_sel == 4'd8);
  assign c2      = (fault_sel == 4'd9);
  assign c3      = (fault_sel == 4'd10);

  assign g1   = v1 ? b : c1 ? maj(~a, b, ~cin) : maj(a, b, cin);
  assign w1   = ~cin ^ (w1_flip | x1);
  assign g2_h = x1 ? w1 : b;
  assign g2   = v2 ? g2_h : c2 ? maj(~a, g2_h, ~w1) : maj(a, g2_h, w1);
  assign w2   = ~g1 ^ (w2_flip | x2);
  assign g3_h = x2 ? w2 : g2;
  assign g3   = v3 ? g3_h : c3 ? maj(~w2, g3_h, ~cin) : maj(w2, g3_h, cin);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          sum  <= 1'b0;
          cout <= 1'b0;
        end else begin
          sum  <= g3;
          cout <= g1;
        end
      end
    end else begin : g_comb
      assign sum  = g3;
      assign cout = g1;
    end
  endgenerate

endmodule

// File: rtl/majfa_defect_chk.sv
module majfa_defect_chk (
  input logic       clk,
  input logic       rst,
  input logic       a,
  input logic       b,
  input logic       cin,
  input logic [3:0] fault_sel,
  input logic       sum,
  input logic       cout
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_reset_clear_r2: assert property (@(posedge clk) disable iff (!armed)
    $past(rst) |-> (!sum && !cout));

  p_clean_add_r1: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) == 4'd0) |->
      ({cout, sum} == 2'($past(a)) + 2'($past(b)) + 2'($past(cin))));

  p_cross_out_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) == 4'd4) |-> (sum == cout));

  p_carry_vert_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) == 4'd5) |-> (cout == $past(b)));

  p_w1_flip_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) == 4'd1) |-> (sum == $past(cin)));

  p_horiz_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) >= 4'd11 && $past(fault_sel) <= 4'd13) |->
      ({cout, sum} == 2'($past(a)) + 2'($past(b)) + 2'($past(cin))));

  p_unused_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    (!$past(rst) && $past(fault_sel) >= 4'd14) |->
      ({cout, sum} == 2'($past(a)) + 2'($past(b)) + 2'($past(cin))));

endmodule

bind majfa_defect majfa_defect_chk u_chk (
  .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
  .fault_sel(fault_sel), .sum(sum), .cout(cout)
);

// File: tb/majfa_defect_test.sv
module majfa_defect_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       a = 1'b0, b = 1'b0, cin = 1'b0;
  logic [3:0] fault_sel = 4'd0;
  logic       sum, cout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic s; logic c; string req; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  majfa_defect uut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
    .fault_sel(fault_sel), .sum(sum), .cout(cout)
  );

  function automatic logic vote(input int x, input int y, input int z);
    return (x + y + z) >= 2;
  endfunction

  function automatic exp_t model(input bit r, input int ai, input int bi,
                                 input int ci, input int code);
    exp_t e;
    int total = ai + bi + ci;
    int carry = total / 2;
    int helper = vote(ai, bi, 1 - ci);
    e.s = total % 2;
    e.c = carry;
    e.req = "R1";
    if (r) begin e.s = 0; e.c = 0; e.req = "R2"; return e; end
    case (code)
      1:  begin e.s = ci; e.req = "R3"; end
      2:  begin e.s = vote(carry, helper, ci); e.req = "R3"; end
      3:  begin e.s = ci; e.req = "R4"; end
      4:  begin e.s = carry; e.req = "R4"; end
      5:  begin e.c = bi; e.s = vote(1 - bi, helper, ci); e.req = "R5"; end
      6:  begin e.s = vote(1 - carry, bi, ci); e.req = "R5"; end
      7:  begin e.s = helper; e.req = "R5"; end
      8:  begin
            e.c = vote(1 - ai, bi, 1 - ci);
            e.s = vote(1 - int'(e.c), helper, ci);
            e.req = "R6";
          end
      9:  begin e.s = vote(1 - carry, vote(1 - ai, bi, ci), ci); e.req = "R6"; end
      10: begin e.s = vote(carry, helper, 1 - ci); e.req = "R6"; end
      11, 12, 13: e.req = "R7";
      14, 15: e.req = "R8";
      default: ;
    endcase
    return e;
  endfunction

  task automatic compare_pending();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    checks++;
    if (sum !== e.s || cout !== e.c) begin
      errors++;
      $display("FAIL %s: got cout=%b sum=%b, expected cout=%b sum=%b",
               e.req, cout, sum, e.c, e.s);
    end
  endtask

  task automatic step(input bit r, input int ai, input int bi,
                      input int ci, input int code);
    @(negedge clk);
    compare_pending();
    rst = r; a = ai[0]; b = bi[0]; cin = ci[0]; fault_sel = code[3:0];
    q.push_back(model(r, ai, bi, ci, code));
  endtask

  initial begin
    step(1, 1, 1, 1, 0);
    step(1, 0, 1, 1, 4);
    for (int code = 0; code < 16; code++)
      for (int v = 0; v < 8; v++)
        step(0, (v >> 2) & 1, (v >> 1) & 1, v & 1, code);
    step(0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0);
    step(0, 1, 1, 1, 8);
    step(0, 0, 0, 1, 5);
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule